// File: doc/BRIEF.md
# Aliased Sub-Register File

This block holds eight 32-bit general registers and a separate 32-bit instruction pointer. Each general register can also be reached through narrower views. The low half (bits 15:0) works as a word view on every register. Registers 0 to 3 also offer two byte views: bits 7:0 and bits 15:8. A narrow write merges its bits into the stored register and leaves every other bit as it was. A narrow read returns the selected slice, shifted down to bit 0 and zero-extended to 32 bits.

There is one write port and two independent read ports. Each port carries a register index and a 2-bit view code. The read ports are combinational. A write lands on the rising clock edge, so a read in the same cycle still sees the previous contents. A byte view named on registers 4 to 7 is rejected: the port raises its error flag, a write is dropped and a read returns zero.

The instruction pointer has its own write port. That port can replace all 32 bits or only the low word.

Top module: `alias_regfile`

## Requirements
- R1: While rst_n is low, every general register and the instruction pointer are cleared to zero, and all of them read zero after reset is released.
- R2: View code 2'b11 (doubleword) writes all 32 bits of any register from wr_data and reads all 32 bits back.
- R3: View code 2'b10 (word) writes wr_data[15:0] into bits 15:0 and keeps bits 31:16. A word read returns bits 15:0 with bits 31:16 of the result at zero.
- R4: View code 2'b00 (low byte) on registers 0 to 3 writes wr_data[7:0] into bits 7:0 and keeps all other bits. A low-byte read returns bits 7:0, zero-extended.
- R5: View code 2'b01 (high byte) on registers 0 to 3 writes wr_data[7:0] into bits 15:8 and keeps all other bits. A high-byte read returns bits 15:8 in result bits 7:0, with the rest zero.
- R6: A byte view (code 2'b00 or 2'b01) on registers 4 to 7 is illegal. On a write, wr_err goes high in that same cycle and no register changes. On a read, that port's rd_err goes high and its rd_data is zero.
- R7: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value is visible from the next cycle.
- R8: The two read ports work independently. Each may name a different register or a different view of the same register in the same cycle.
- R9: When ip_we is high, ip_wide=1 loads all 32 bits of ip_wdata into the instruction pointer. ip_wide=0 loads only ip_wdata[15:0] into bits 15:0 and keeps bits 31:16. ip_q shows the stored value.
- R10: While wr_en is low, no general register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write request for a general register |
| wr_idx | input | 3 | Index of the register to write |
| wr_view | input | 2 | View code of the write |
| wr_data | input | 32 | Write data, taken from its low bits for narrow views |
| wr_err | output | 1 | Illegal write view; the write is dropped |
| rd_idx | input | 2x3 | Register index for each read port |
| rd_view | input | 2x2 | View code for each read port |
| rd_data | output | 2x32 | Zero-extended read result for each port |
| rd_err | output | 2 | Illegal read view for each port |
| ip_we | input | 1 | Instruction pointer write enable |
| ip_wide | input | 1 | 1 writes all 32 bits of the instruction pointer, 0 writes only its low word |
| ip_wdata | input | 32 | Instruction pointer write data |
| ip_q | output | 32 | Current instruction pointer |

## Verification
The bench builds the block with its default parameters: eight registers of 32 bits, byte views on the first four, and two read ports. These values put the legality boundary between indices 3 and 4 in reach, so byte views are driven on both sides of it. The 16-bit word boundary and the second byte are also exercised, each with patterns whose kept and replaced bits differ. Same-cycle read-during-write on one register is covered, as is the case where both read ports take different views of one register at once.

// File: rtl/arf_pkg.sv
package arf_pkg;
  typedef enum logic [1:0] {
    VW_BLO   = 2'b00,
    VW_BHI   = 2'b01,
    VW_WORD  = 2'b10,
    VW_DWORD = 2'b11
  } view_e;
endpackage

// File: rtl/arf_wmerge.sv
module arf_wmerge
  import arf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] wr_val,
  input  view_e           view,
  output logic [XLEN-1:0] new_val
);
  localparam int HALF = XLEN / 2;
  localparam int BYTE = 8;

  // Only the field selected by the view takes new bits; everything else is carried over.
  always_comb begin
    new_val = old_val;
    unique case (view)
      VW_BLO:   new_val[BYTE-1:0]      = wr_val[BYTE-1:0];
      VW_BHI:   new_val[2*BYTE-1:BYTE] = wr_val[BYTE-1:0];
      VW_WORD:  new_val[HALF-1:0]      = wr_val[HALF-1:0];
      default:  new_val                = wr_val;
    endcase
  end
endmodule

// File: rtl/arf_rdport.sv
module arf_rdport
  import arf_pkg::*;
#(
  parameter int NREGS     = 8,
  parameter int XLEN      = 32,
  parameter int NBYTEREGS = 4,
  parameter int IDXW      = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][XLEN-1:0] gpr,
  input  logic [IDXW-1:0]            idx,
  input  view_e                      view,
  output logic [XLEN-1:0]            data,
  output logic                       err
);
  localparam int HALF = XLEN / 2;
  localparam int BYTE = 8;

  logic [XLEN-1:0] sel;
  logic            legal;

  assign sel   = gpr[idx];
  assign legal = (view == VW_WORD) || (view == VW_DWORD) || (int'(idx) < NBYTEREGS);
  assign err   = ~legal;

  always_comb begin
    data = '0;
    if (legal) begin
      unique case (view)
        VW_BLO:  data[BYTE-1:0] = sel[BYTE-1:0];
        VW_BHI:  data[BYTE-1:0] = sel[2*BYTE-1:BYTE];
        VW_WORD: data[HALF-1:0] = sel[HALF-1:0];
        default: data           = sel;
      endcase
    end
  end

  // R6
  always_comb begin
    if (err) begin
      rd_err_zero_chk: assert (data == '0);
    end
  end

  // R3
  always_comb begin
    if (view != VW_DWORD) begin
      rd_zext_chk: assert (data[XLEN-1:HALF] == '0);
    end
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import arf_pkg::*;
#(
  parameter int NREGS     = 8,
  parameter int XLEN      = 32,
  parameter int NBYTEREGS = 4,
  parameter int NRD       = 2,
  parameter int IDXW      = $clog2(NREGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDXW-1:0]           wr_idx,
  input  logic [1:0]                wr_view,
  input  logic [XLEN-1:0]           wr_data,
  output logic                      wr_err,
  input  logic [NRD-1:0][IDXW-1:0]  rd_idx,
  input  logic [NRD-1:0][1:0]       rd_view,
  output logic [NRD-1:0][XLEN-1:0]  rd_data,
  output logic [NRD-1:0]            rd_err,
  input  logic                      ip_we,
  input  logic                      ip_wide,
  input  logic [XLEN-1:0]           ip_wdata,
  output logic [XLEN-1:0]           ip_q
);
  localparam int HALF = XLEN / 2;
  localparam int BYTE = 8;

  logic [NREGS-1:0][XLEN-1:0] gpr_q;
  logic [NREGS-1:0][XLEN-1:0] gpr_d;
  logic [NREGS-1:0]           gpr_en;
  logic [XLEN-1:0]            wr_merged;
  view_e                      wr_view_e;
  logic                       wr_legal;

  logic [XLEN-1:0]            ip_r;
  logic [XLEN-1:0]            ip_d;
  view_e                      ip_view;

  // Write-side legality: byte views exist only below NBYTEREGS.
  assign wr_view_e = view_e'(wr_view);
  assign wr_legal  = (wr_view_e == VW_WORD) || (wr_view_e == VW_DWORD) ||
                     (int'(wr_idx) < NBYTEREGS);
  assign wr_err    = wr_en & ~wr_legal;

  arf_wmerge #(.XLEN(XLEN)) u_wmerge (
    .old_val (gpr_q[wr_idx]),
    .wr_val  (wr_data),
    .view    (wr_view_e),
    .new_val (wr_merged)
  );

  // Next state and per-entry clock enables.
  always_comb begin
    for (int i = 0; i < NREGS; i++) begin
      gpr_en[i] = wr_en && wr_legal && (int'(wr_idx) == i);
      gpr_d[i]  = gpr_en[i] ? wr_merged : gpr_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpr_q <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (gpr_en[i]) gpr_q[i] <= gpr_d[i];
      end
    end
  end

  // Instruction pointer: word or doubleword loads only.
  assign ip_view = ip_wide ? VW_DWORD : VW_WORD;

  arf_wmerge #(.XLEN(XLEN)) u_ipmerge (
    .old_val (ip_r),
    .wr_val  (ip_wdata),
    .view    (ip_view),
    .new_val (ip_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_r <= '0;
    end else if (ip_we) begin
      ip_r <= ip_d;
    end
  end

  assign ip_q = ip_r;

  // Read ports, one slice unit each.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    arf_rdport #(
      .NREGS     (NREGS),
      .XLEN      (XLEN),
      .NBYTEREGS (NBYTEREGS),
      .IDXW      (IDXW)
    ) u_rdport (
      .gpr  (gpr_q),
      .idx  (rd_idx[p]),
      .view (view_e'(rd_view[p])),
      .data (rd_data[p]),
      .err  (rd_err[p])
    );
  end

  // R6
  wr_illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> $stable(gpr_q));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(gpr_q));

  // R3
  word_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_view_e == VW_WORD) |=>
      gpr_q[$past(wr_idx)][XLEN-1:HALF] == $past(gpr_q[wr_idx][XLEN-1:HALF]));

  // R5
  bhi_low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_view_e == VW_BHI && wr_legal) |=>
      gpr_q[$past(wr_idx)][BYTE-1:0] == $past(gpr_q[wr_idx][BYTE-1:0]));

  // R9
  ip_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_we && !ip_wide) |=> ip_q[XLEN-1:HALF] == $past(ip_q[XLEN-1:HALF]));
endmodule

// File: tb/sim_alias_regfile.sv
`timescale 1ns/1ps
module sim_alias_regfile;
  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en;
  logic [2:0]       wr_idx;
  logic [1:0]       wr_view;
  logic [31:0]      wr_data;
  logic             wr_err;
  logic [1:0][2:0]  rd_idx;
  logic [1:0][1:0]  rd_view;
  logic [1:0][31:0] rd_data;
  logic [1:0]       rd_err;
  logic             ip_we;
  logic             ip_wide;
  logic [31:0]      ip_wdata;
  logic [31:0]      ip_q;

  always #2.5 clk = ~clk;

  alias_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data), .wr_err(wr_err),
    .rd_idx(rd_idx), .rd_view(rd_view), .rd_data(rd_data), .rd_err(rd_err),
    .ip_we(ip_we), .ip_wide(ip_wide), .ip_wdata(ip_wdata), .ip_q(ip_q)
  );

  typedef struct {
    string       req;
    logic [31:0] d0, d1, ip;
    logic        e0, e1, we;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] m_gpr[8];
  logic [31:0] m_ip;
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 0;

  function automatic bit view_ok(input int idx, input logic [1:0] v);
    return (v[1] == 1'b1) || (idx < 4);
  endfunction

  function automatic logic [31:0] rd_model(input int idx, input logic [1:0] v);
    logic [31:0] r = m_gpr[idx];
    if (!view_ok(idx, v)) return 32'h0;
    case (v)
      2'b00:   return {24'h0, r[7:0]};
      2'b01:   return {24'h0, r[15:8]};
      2'b10:   return {16'h0, r[15:0]};
      default: return r;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, queues what the outputs must show before the edge.
  task automatic op(input string req,
                    input logic we, input int wi, input logic [1:0] wv, input logic [31:0] wd,
                    input int r0, input logic [1:0] v0, input int r1, input logic [1:0] v1,
                    input logic ipw = 1'b0, input logic ipwide = 1'b0, input logic [31:0] ipd = '0);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_idx = 3'(wi); wr_view = wv; wr_data = wd;
    rd_idx[0] = 3'(r0); rd_view[0] = v0; rd_idx[1] = 3'(r1); rd_view[1] = v1;
    ip_we = ipw; ip_wide = ipwide; ip_wdata = ipd;
    e.req = req;
    e.d0 = rd_model(r0, v0); e.e0 = !view_ok(r0, v0);
    e.d1 = rd_model(r1, v1); e.e1 = !view_ok(r1, v1);
    e.we = we && !view_ok(wi, wv);
    e.ip = m_ip;
    sb.push_back(e);
    if (we && view_ok(wi, wv)) begin
      case (wv)
        2'b00:   m_gpr[wi][7:0]  = wd[7:0];
        2'b01:   m_gpr[wi][15:8] = wd[7:0];
        2'b10:   m_gpr[wi][15:0] = wd[15:0];
        default: m_gpr[wi]       = wd;
      endcase
    end
    if (ipw) begin
      if (ipwide) m_ip = ipd;
      else        m_ip[15:0] = ipd[15:0];
    end
  endtask

  // Monitor: compares queued expectations one time unit after the falling edge.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(e.req, "rd_data0", rd_data[0], e.d0);
        chk(e.req, "rd_data1", rd_data[1], e.d1);
        chk(e.req, "rd_err0", {31'h0, rd_err[0]}, {31'h0, e.e0});
        chk(e.req, "rd_err1", {31'h0, rd_err[1]}, {31'h0, e.e1});
        chk(e.req, "wr_err", {31'h0, wr_err}, {31'h0, e.we});
        chk(e.req, "ip_q", ip_q, e.ip);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_gpr[i] = 32'h0;
    m_ip = 32'h0;
    rst_n = 1'b0; wr_en = 0; wr_idx = 0; wr_view = 0; wr_data = 0;
    rd_idx = '0; rd_view = '0; ip_we = 0; ip_wide = 0; ip_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state on every register and the instruction pointer
    for (int i = 0; i < 8; i += 2) op("R1", 0, 0, 2'b11, 32'h0, i, 2'b11, i + 1, 2'b11);

    // R2 doubleword writes and reads
    op("R2", 1, 0, 2'b11, 32'h11223344, 0, 2'b11, 7, 2'b11);
    op("R2", 1, 5, 2'b11, 32'hA5A55A5A, 0, 2'b11, 5, 2'b11);
    op("R2", 1, 7, 2'b11, 32'hDEADBEEF, 5, 2'b11, 7, 2'b11);
    op("R2", 1, 1, 2'b11, 32'hCAFEBABE, 7, 2'b11, 1, 2'b11);
    op("R2", 1, 2, 2'b11, 32'h89ABCDEF, 1, 2'b11, 2, 2'b11);
    op("R2", 1, 4, 2'b11, 32'h13579BDF, 2, 2'b11, 4, 2'b11);

    // R3 word view merge and zero extension
    op("R3", 1, 5, 2'b10, 32'hFFFF1234, 5, 2'b10, 5, 2'b11);
    op("R3", 0, 0, 2'b10, 32'h0, 5, 2'b10, 5, 2'b11);
    op("R3", 1, 0, 2'b10, 32'h0000C0DE, 0, 2'b11, 4, 2'b10);
    op("R3", 0, 0, 2'b10, 32'h0, 0, 2'b11, 0, 2'b10);

    // R4 low byte on the first four registers
    op("R4", 1, 1, 2'b00, 32'hFFFFFF77, 1, 2'b00, 1, 2'b11);
    op("R4", 1, 3, 2'b00, 32'h000000A1, 1, 2'b00, 1, 2'b11);
    op("R4", 0, 0, 2'b00, 32'h0, 3, 2'b00, 3, 2'b11);

    // R5 high byte on the first four registers, boundary index 3
    op("R5", 1, 2, 2'b01, 32'hFFFFFF42, 2, 2'b01, 2, 2'b11);
    op("R5", 1, 3, 2'b01, 32'h000000E5, 2, 2'b01, 2, 2'b11);
    op("R5", 0, 0, 2'b01, 32'h0, 3, 2'b01, 3, 2'b11);

    // R6 byte views on registers 4..7 rejected
    op("R6", 1, 4, 2'b01, 32'h000000FF, 4, 2'b01, 4, 2'b11);
    op("R6", 1, 6, 2'b00, 32'h000000FF, 7, 2'b00, 4, 2'b11);
    op("R6", 1, 7, 2'b01, 32'h00000011, 6, 2'b11, 7, 2'b11);
    op("R6", 0, 0, 2'b11, 32'h0, 5, 2'b00, 7, 2'b11);

    // R7 read during write returns the old value, new value next cycle
    op("R7", 1, 3, 2'b11, 32'h0BADF00D, 3, 2'b11, 3, 2'b10);
    op("R7", 1, 3, 2'b01, 32'h0000005C, 3, 2'b11, 3, 2'b01);
    op("R7", 0, 0, 2'b11, 32'h0, 3, 2'b11, 3, 2'b01);

    // R8 two ports, different views of one register and different registers
    op("R8", 0, 0, 2'b11, 32'h0, 2, 2'b00, 2, 2'b01);
    op("R8", 0, 0, 2'b11, 32'h0, 1, 2'b10, 7, 2'b10);

    // R9 instruction pointer full and word loads
    op("R9", 0, 0, 2'b11, 32'h0, 0, 2'b11, 1, 2'b11, 1'b1, 1'b1, 32'h12345678);
    op("R9", 0, 0, 2'b11, 32'h0, 0, 2'b11, 1, 2'b11, 1'b1, 1'b0, 32'hFFFFABCD);
    op("R9", 0, 0, 2'b11, 32'h0, 0, 2'b11, 1, 2'b11, 1'b0, 1'b1, 32'h0);

    // R10 write inputs ignored while wr_en is low
    op("R10", 0, 6, 2'b11, 32'h55555555, 6, 2'b11, 5, 2'b11);
    op("R10", 0, 0, 2'b11, 32'hFFFFFFFF, 6, 2'b11, 0, 2'b11);

    op("R10", 0, 0, 2'b11, 32'h0, 0, 2'b11, 6, 2'b11);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule